// File: doc/BRIEF.md
# Bundle Next-PC and Link Unit

This block holds the program counter of a core that fetches one 64-bit instruction bundle per cycle. It picks the address of the next bundle to fetch. It also produces the return address for link-type control transfers. Each cycle the decode stage presents the control-transfer kind of the bundle at the current PC, together with its branch offset, jump offset, register-indirect target and branch-taken flag. Three events with their own addresses can arrive at the same time: an interrupt with its vector, a mispredict redirect with the corrected target, and a return-from-interrupt with the saved PC. The unit ranks all candidates, adds bundle offsets after scaling them to bytes, and loads the result into the PC register.

Offsets count whole bundles. A branch offset is a signed 16-bit bundle count and a jump offset is a signed 28-bit bundle count. Both are taken relative to the current bundle. Every address the unit loads is forced to an 8-byte boundary. The control pins are plain levels with no handshake. A stall input freezes the PC and holds back the link write. Outside a stall the unit takes a new bundle every cycle, so it applies no back-pressure of its own.

Top module: `bundle_npc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc` loads the reset vector (default 0x10000).
- R2: While `stall` is high, `pc` keeps its value across the clock edge, `next_pc` equals `pc`, and `link_we` is low.
- R3: With no event pending, kinds 0 (none), 6 (link only), 7 (reserved), and kind 1 with `br_taken` low, advance `pc` by 8.
- R4: Kind 1 (conditional branch) with `br_taken` high loads `pc` + sign-extended `br_off` × 8.
- R5: Kinds 2 (jump) and 3 (jump and link) load `pc` + sign-extended 28-bit `jmp_off` × 8, so the top offset bit set jumps backward.
- R6: Kinds 4 (register jump) and 5 (register jump and link) load `reg_tgt` with bits 2:0 cleared.
- R7: Kinds 3 and 5 raise `link_we` with `link_reg` = 55. Kind 6 raises `link_we` with `link_reg` = `link_dest`. In all three cases `link_val` = `pc` + 8.
- R8: Source priority from highest to lowest is `irq_valid`, `misp_valid`, `eret_valid`, the bundle's transfer, then sequential. The event addresses `irq_vec`, `misp_tgt` and `eret_pc` are loaded with bits 2:0 cleared.
- R9: `link_we` is low in any cycle where `irq_valid`, `misp_valid` or `eret_valid` is high.
- R10: Bits 2:0 of `pc` are zero at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Freeze PC and suppress link write |
| xfer_kind | input | 3 | Control-transfer kind of the current bundle (0..7, see R3–R7) |
| br_off | input | 16 | Signed branch offset in bundles |
| jmp_off | input | 28 | Signed jump offset in bundles |
| reg_tgt | input | 64 | Register-indirect jump target |
| br_taken | input | 1 | Conditional branch resolves taken |
| link_dest | input | 6 | Destination register of the link-only kind |
| misp_valid | input | 1 | Mispredict redirect request |
| misp_tgt | input | 64 | Corrected fetch address |
| irq_valid | input | 1 | Interrupt request |
| irq_vec | input | 64 | Interrupt vector address |
| eret_valid | input | 1 | Return-from-interrupt request |
| eret_pc | input | 64 | Saved PC to resume at |
| pc | output | 64 | Current bundle address |
| next_pc | output | 64 | Address `pc` loads at the next edge |
| link_val | output | 64 | Return address, `pc` + 8 |
| link_we | output | 1 | Link register write enable |
| link_reg | output | 6 | Link register index |

## Verification
The link outputs and `next_pc` are combinational from the inputs and the current `pc`, so they are due in the same cycle. The bench checks them one time unit after driving the inputs on the falling edge. The `pc` register changes one rising edge later. The bench therefore samples `pc` one time unit after that edge and compares it with the value its own model predicted from the previous cycle's inputs. Before each edge, the model carries its expected PC forward, or holds it while `stall` or `rst` is high.

// File: rtl/npc_pkg.sv
package npc_pkg;

  // Control-transfer kind decoded from the current bundle
  typedef enum logic [2:0] {
    XF_NONE      = 3'd0,
    XF_BRANCH    = 3'd1,
    XF_JUMP      = 3'd2,
    XF_JUMP_LINK = 3'd3,
    XF_JREG      = 3'd4,
    XF_JREG_LINK = 3'd5,
    XF_LINK_ONLY = 3'd6,
    XF_RSVD      = 3'd7
  } xfer_kind_e;

  // Which candidate won the next-PC selection
  typedef enum logic [2:0] {
    SRC_SEQ  = 3'd0,
    SRC_XFER = 3'd1,
    SRC_ERET = 3'd2,
    SRC_MISP = 3'd3,
    SRC_IRQ  = 3'd4
  } npc_src_e;

  // Byte address bits below a bundle boundary
  localparam int unsigned BUNDLE_SHIFT = 3;

endpackage

// File: rtl/npc_align_bank.sv
module npc_align_bank #(
  parameter int unsigned W     = 64,
  parameter int unsigned N     = 4,
  parameter int unsigned SHIFT = 3
) (
  input  logic [N-1:0][W-1:0] raw,
  output logic [N-1:0][W-1:0] aligned
);
  localparam logic [W-1:0] LOW_MASK = W'((1 << SHIFT) - 1);

  for (genvar i = 0; i < N; i++) begin : g_lane
    assign aligned[i] = raw[i] & ~LOW_MASK;
  end

endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen
  import npc_pkg::*;
#(
  parameter int unsigned PC_W  = 64,
  parameter int unsigned BR_W  = 16,
  parameter int unsigned JMP_W = 28
) (
  input  logic [PC_W-1:0]  pc,
  input  xfer_kind_e       kind,
  input  logic [BR_W-1:0]  br_off,
  input  logic [JMP_W-1:0] jmp_off,
  input  logic [PC_W-1:0]  reg_tgt_al,
  input  logic             br_taken,
  output logic [PC_W-1:0]  seq_pc,
  output logic [PC_W-1:0]  xfer_tgt,
  output logic             xfer_take
);
  localparam int unsigned BR_PAD  = PC_W - BR_W - BUNDLE_SHIFT;
  localparam int unsigned JMP_PAD = PC_W - JMP_W - BUNDLE_SHIFT;
  localparam logic [PC_W-1:0] STEP = PC_W'(1 << BUNDLE_SHIFT);

  logic [PC_W-1:0] br_bytes;
  logic [PC_W-1:0] jmp_bytes;
  logic [PC_W-1:0] br_tgt;
  logic [PC_W-1:0] jmp_tgt;

  // Bundle counts scaled to bytes with sign extension
  assign br_bytes  = {{BR_PAD{br_off[BR_W-1]}}, br_off, {BUNDLE_SHIFT{1'b0}}};
  assign jmp_bytes = {{JMP_PAD{jmp_off[JMP_W-1]}}, jmp_off, {BUNDLE_SHIFT{1'b0}}};

  assign seq_pc  = pc + STEP;
  assign br_tgt  = pc + br_bytes;
  assign jmp_tgt = pc + jmp_bytes;

  always_comb begin
    xfer_take = 1'b0;
    xfer_tgt  = seq_pc;
    unique case (kind)
      XF_BRANCH: begin
        xfer_take = br_taken;
        xfer_tgt  = br_tgt;
      end
      XF_JUMP, XF_JUMP_LINK: begin
        xfer_take = 1'b1;
        xfer_tgt  = jmp_tgt;
      end
      XF_JREG, XF_JREG_LINK: begin
        xfer_take = 1'b1;
        xfer_tgt  = reg_tgt_al;
      end
      default: begin
        xfer_take = 1'b0;
        xfer_tgt  = seq_pc;
      end
    endcase
  end

endmodule

// File: rtl/npc_link_gen.sv
module npc_link_gen
  import npc_pkg::*;
#(
  parameter int unsigned PC_W     = 64,
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned LINK_REG = 55
) (
  input  logic [PC_W-1:0]  seq_pc,
  input  xfer_kind_e       kind,
  input  logic [IDX_W-1:0] link_dest,
  input  logic             squash,
  output logic [PC_W-1:0]  link_val,
  output logic             link_we,
  output logic [IDX_W-1:0] link_reg
);
  localparam logic [IDX_W-1:0] FIXED_IDX = IDX_W'(LINK_REG);

  logic wants_link;

  always_comb begin
    wants_link = 1'b0;
    link_reg   = FIXED_IDX;
    unique case (kind)
      XF_JUMP_LINK, XF_JREG_LINK: begin
        wants_link = 1'b1;
        link_reg   = FIXED_IDX;
      end
      XF_LINK_ONLY: begin
        wants_link = 1'b1;
        link_reg   = link_dest;
      end
      default: begin
        wants_link = 1'b0;
        link_reg   = FIXED_IDX;
      end
    endcase
  end

  assign link_val = seq_pc;
  assign link_we  = wants_link & ~squash;

endmodule

// File: rtl/npc_source_sel.sv
module npc_source_sel
  import npc_pkg::*;
#(
  parameter int unsigned PC_W = 64
) (
  input  logic            irq_req,
  input  logic [PC_W-1:0] irq_addr,
  input  logic            misp_req,
  input  logic [PC_W-1:0] misp_addr,
  input  logic            eret_req,
  input  logic [PC_W-1:0] eret_addr,
  input  logic            xfer_take,
  input  logic [PC_W-1:0] xfer_tgt,
  input  logic [PC_W-1:0] seq_pc,
  output logic [PC_W-1:0] sel_pc,
  output npc_src_e        sel_src
);

  always_comb begin
    if (irq_req) begin
      sel_src = SRC_IRQ;
      sel_pc  = irq_addr;
    end else if (misp_req) begin
      sel_src = SRC_MISP;
      sel_pc  = misp_addr;
    end else if (eret_req) begin
      sel_src = SRC_ERET;
      sel_pc  = eret_addr;
    end else if (xfer_take) begin
      sel_src = SRC_XFER;
      sel_pc  = xfer_tgt;
    end else begin
      sel_src = SRC_SEQ;
      sel_pc  = seq_pc;
    end
  end

endmodule

// File: rtl/bundle_npc_unit.sv
module bundle_npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned     PC_W      = 64,
  parameter int unsigned     BR_W      = 16,
  parameter int unsigned     JMP_W     = 28,
  parameter int unsigned     IDX_W     = 6,
  parameter int unsigned     LINK_REG  = 55,
  parameter logic [PC_W-1:0] RESET_VEC = PC_W'(64'h1_0000)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stall,
  input  logic [2:0]       xfer_kind,
  input  logic [BR_W-1:0]  br_off,
  input  logic [JMP_W-1:0] jmp_off,
  input  logic [PC_W-1:0]  reg_tgt,
  input  logic             br_taken,
  input  logic [IDX_W-1:0] link_dest,
  input  logic             misp_valid,
  input  logic [PC_W-1:0]  misp_tgt,
  input  logic             irq_valid,
  input  logic [PC_W-1:0]  irq_vec,
  input  logic             eret_valid,
  input  logic [PC_W-1:0]  eret_pc,
  output logic [PC_W-1:0]  pc,
  output logic [PC_W-1:0]  next_pc,
  output logic [PC_W-1:0]  link_val,
  output logic             link_we,
  output logic [IDX_W-1:0] link_reg
);
  localparam int unsigned N_ADDR = 4;
  localparam int unsigned A_IRQ  = 0;
  localparam int unsigned A_MISP = 1;
  localparam int unsigned A_ERET = 2;
  localparam int unsigned A_REG  = 3;
  localparam logic [PC_W-1:0] RESET_AL =
    RESET_VEC & ~PC_W'((1 << BUNDLE_SHIFT) - 1);

  xfer_kind_e kind;
  npc_src_e   sel_src;

  logic [N_ADDR-1:0][PC_W-1:0] raw_addr;
  logic [N_ADDR-1:0][PC_W-1:0] al_addr;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] xfer_tgt;
  logic [PC_W-1:0] sel_pc;
  logic            xfer_take;
  logic            squash;

  assign kind = xfer_kind_e'(xfer_kind);

  assign raw_addr[A_IRQ]  = irq_vec;
  assign raw_addr[A_MISP] = misp_tgt;
  assign raw_addr[A_ERET] = eret_pc;
  assign raw_addr[A_REG]  = reg_tgt;

  npc_align_bank #(
    .W     (PC_W),
    .N     (N_ADDR),
    .SHIFT (BUNDLE_SHIFT)
  ) u_align (
    .raw     (raw_addr),
    .aligned (al_addr)
  );

  npc_target_gen #(
    .PC_W  (PC_W),
    .BR_W  (BR_W),
    .JMP_W (JMP_W)
  ) u_tgt (
    .pc         (pc_q),
    .kind       (kind),
    .br_off     (br_off),
    .jmp_off    (jmp_off),
    .reg_tgt_al (al_addr[A_REG]),
    .br_taken   (br_taken),
    .seq_pc     (seq_pc),
    .xfer_tgt   (xfer_tgt),
    .xfer_take  (xfer_take)
  );

  npc_source_sel #(
    .PC_W (PC_W)
  ) u_sel (
    .irq_req   (irq_valid),
    .irq_addr  (al_addr[A_IRQ]),
    .misp_req  (misp_valid),
    .misp_addr (al_addr[A_MISP]),
    .eret_req  (eret_valid),
    .eret_addr (al_addr[A_ERET]),
    .xfer_take (xfer_take),
    .xfer_tgt  (xfer_tgt),
    .seq_pc    (seq_pc),
    .sel_pc    (sel_pc),
    .sel_src   (sel_src)
  );

  // The bundle at pc commits nothing when it is stalled or displaced
  assign squash = stall | irq_valid | misp_valid | eret_valid;

  npc_link_gen #(
    .PC_W     (PC_W),
    .IDX_W    (IDX_W),
    .LINK_REG (LINK_REG)
  ) u_link (
    .seq_pc    (seq_pc),
    .kind      (kind),
    .link_dest (link_dest),
    .squash    (squash),
    .link_val  (link_val),
    .link_we   (link_we),
    .link_reg  (link_reg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= RESET_AL;
    end else if (!stall) begin
      pc_q <= sel_pc;
    end
  end

  assign pc      = pc_q;
  assign next_pc = stall ? pc_q : sel_pc;

  logic unused_src;
  assign unused_src = ^sel_src;

endmodule

// File: rtl/bundle_npc_unit_chk.sv
module bundle_npc_unit_chk #(
  parameter int unsigned     PC_W      = 64,
  parameter int unsigned     IDX_W     = 6,
  parameter int unsigned     LINK_REG  = 55,
  parameter logic [PC_W-1:0] RESET_VEC = PC_W'(64'h1_0000)
) (
  input logic             clk,
  input logic             rst,
  input logic             stall,
  input logic             irq_valid,
  input logic [PC_W-1:0]  irq_vec,
  input logic             misp_valid,
  input logic [PC_W-1:0]  misp_tgt,
  input logic             eret_valid,
  input logic [2:0]       xfer_kind,
  input logic [PC_W-1:0]  pc,
  input logic [PC_W-1:0]  link_val,
  input logic             link_we,
  input logic [IDX_W-1:0] link_reg
);
  localparam logic [PC_W-1:0] AL_MASK = ~PC_W'(7);

  a_r1_reset_vector: assert property (@(posedge clk)
    rst |=> pc == (RESET_VEC & AL_MASK));

  a_r2_stall_holds_pc: assert property (@(posedge clk) disable iff (rst)
    stall |=> pc == $past(pc));

  a_r2_stall_no_link: assert property (@(posedge clk) disable iff (rst)
    stall |-> !link_we);

  a_r7_link_value: assert property (@(posedge clk) disable iff (rst)
    link_we |-> link_val == pc + PC_W'(8));

  a_r7_fixed_link_index: assert property (@(posedge clk) disable iff (rst)
    (link_we && xfer_kind != 3'd6) |-> link_reg == IDX_W'(LINK_REG));

  a_r8_irq_first: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && !stall) |=> pc == ($past(irq_vec) & AL_MASK));

  a_r8_misp_second: assert property (@(posedge clk) disable iff (rst)
    (misp_valid && !irq_valid && !stall) |=> pc == ($past(misp_tgt) & AL_MASK));

  a_r9_event_blocks_link: assert property (@(posedge clk) disable iff (rst)
    (irq_valid || misp_valid || eret_valid) |-> !link_we);

  a_r10_pc_aligned: assert property (@(posedge clk) disable iff (rst)
    pc[2:0] == 3'b000);

endmodule

bind bundle_npc_unit bundle_npc_unit_chk #(
  .PC_W      (PC_W),
  .IDX_W     (IDX_W),
  .LINK_REG  (LINK_REG),
  .RESET_VEC (RESET_VEC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .stall      (stall),
  .irq_valid  (irq_valid),
  .irq_vec    (irq_vec),
  .misp_valid (misp_valid),
  .misp_tgt   (misp_tgt),
  .eret_valid (eret_valid),
  .xfer_kind  (xfer_kind),
  .pc         (pc),
  .link_val   (link_val),
  .link_we    (link_we),
  .link_reg   (link_reg)
);

// File: tb/bundle_npc_unit_test.sv
`timescale 1ns/1ps
module bundle_npc_unit_test;

  localparam logic [63:0] RST_PC = 64'h1_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic [2:0]  xfer_kind = 3'd0;
  logic [15:0] br_off = '0;
  logic [27:0] jmp_off = '0;
  logic [63:0] reg_tgt = '0;
  logic        br_taken = 1'b0;
  logic [5:0]  link_dest = '0;
  logic        misp_valid = 1'b0;
  logic [63:0] misp_tgt = '0;
  logic        irq_valid = 1'b0;
  logic [63:0] irq_vec = '0;
  logic        eret_valid = 1'b0;
  logic [63:0] eret_pc = '0;
  logic [63:0] pc, next_pc, link_val;
  logic        link_we;
  logic [5:0]  link_reg;

  int checks = 0;
  int failures = 0;
  logic [63:0] model_pc;

  always #2 clk = ~clk;

  bundle_npc_unit uut (
    .clk(clk), .rst(rst), .stall(stall), .xfer_kind(xfer_kind),
    .br_off(br_off), .jmp_off(jmp_off), .reg_tgt(reg_tgt),
    .br_taken(br_taken), .link_dest(link_dest),
    .misp_valid(misp_valid), .misp_tgt(misp_tgt),
    .irq_valid(irq_valid), .irq_vec(irq_vec),
    .eret_valid(eret_valid), .eret_pc(eret_pc),
    .pc(pc), .next_pc(next_pc), .link_val(link_val),
    .link_we(link_we), .link_reg(link_reg)
  );

  task automatic check64(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] predict_pc(input logic [63:0] cur);
    logic [63:0] al;
    al = ~64'h7;
    if (stall) return cur;
    if (irq_valid) return irq_vec & al;
    if (misp_valid) return misp_tgt & al;
    if (eret_valid) return eret_pc & al;
    case (xfer_kind)
      3'd1: return br_taken ? cur + ({{48{br_off[15]}}, br_off} * 64'd8) : cur + 64'd8;
      3'd2, 3'd3: return cur + ({{36{jmp_off[27]}}, jmp_off} * 64'd8);
      3'd4, 3'd5: return reg_tgt & al;
      default: return cur + 64'd8;
    endcase
  endfunction

  function automatic string req_tag();
    if (stall) return "R2";
    if (irq_valid || misp_valid || eret_valid) return "R8";
    case (xfer_kind)
      3'd1: return br_taken ? "R4" : "R3";
      3'd2, 3'd3: return "R5";
      3'd4, 3'd5: return "R6";
      default: return "R3";
    endcase
  endfunction

  // Inputs set on the falling edge; combinational results checked 1 ns
  // later; the PC register checked 1 ns after the following rising edge.
  task automatic step();
    logic [63:0] exp_pc;
    logic        exp_we;
    logic [5:0]  exp_idx;
    string       tag;
    tag = req_tag();
    exp_pc = predict_pc(model_pc);
    exp_we = !stall && !irq_valid && !misp_valid && !eret_valid &&
             (xfer_kind == 3'd3 || xfer_kind == 3'd5 || xfer_kind == 3'd6);
    exp_idx = (xfer_kind == 3'd6) ? link_dest : 6'd55;
    #1;
    check64(tag, "next_pc", next_pc, exp_pc);
    check64((stall ? "R2" : (irq_valid || misp_valid || eret_valid) ? "R9" : "R7"),
            "link_we", {63'd0, link_we}, {63'd0, exp_we});
    if (exp_we) begin
      check64("R7", "link_val", link_val, model_pc + 64'd8);
      check64("R7", "link_reg", {58'd0, link_reg}, {58'd0, exp_idx});
    end
    @(posedge clk); #1;
    check64(tag, "pc", pc, exp_pc);
    check64("R10", "pc_low_bits", {61'd0, pc[2:0]}, 64'd0);
    model_pc = exp_pc;
    @(negedge clk);
  endtask

  task automatic quiet();
    stall = 0; irq_valid = 0; misp_valid = 0; eret_valid = 0;
    xfer_kind = 3'd0; br_taken = 0;
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    @(posedge clk); #1;
    check64("R1", "reset pc", pc, RST_PC);
    @(negedge clk);
    rst = 0;
    model_pc = RST_PC;

    // R3 sequential, reserved kind and untaken branch
    quiet(); step();
    xfer_kind = 3'd7; step();
    xfer_kind = 3'd1; br_off = 16'h0040; br_taken = 0; step();
    // R4 extreme offsets
    br_taken = 1; br_off = 16'h8000; step();
    br_off = 16'h7FFF; step();
    // R5 jump, backward via top bit, and jump-and-link
    quiet(); xfer_kind = 3'd2; jmp_off = 28'h800_0000; step();
    jmp_off = 28'h7FF_FFFF; step();
    xfer_kind = 3'd3; jmp_off = 28'hFFF_FFFF; step();
    // R6 misaligned register target
    xfer_kind = 3'd5; reg_tgt = 64'h1234_5678_9ABC_DEF7; step();
    xfer_kind = 3'd4; reg_tgt = 64'h0000_0000_0000_0105; step();
    // R7 link-only with explicit destination
    xfer_kind = 3'd6; link_dest = 6'd17; step();
    // R2 stall with a linking jump pending
    xfer_kind = 3'd3; stall = 1; step(); step();
    // R8 all events at once, then step down the ranking
    stall = 0; irq_valid = 1; misp_valid = 1; eret_valid = 1;
    irq_vec = 64'hFFFF_0000_0000_0803; misp_tgt = 64'hA5A5_0000_0000_1001;
    eret_pc = 64'h0000_0000_00C0_FFEE; xfer_kind = 3'd5; step();
    irq_valid = 0; step();
    misp_valid = 0; step();
    eret_valid = 0; step();

    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      stall      = (r < 8);
      irq_valid  = ($urandom_range(0, 99) < 5);
      misp_valid = ($urandom_range(0, 99) < 7);
      eret_valid = ($urandom_range(0, 99) < 5);
      xfer_kind  = 3'($urandom_range(0, 7));
      br_taken   = $urandom_range(0, 1) == 1;
      br_off     = 16'($urandom);
      jmp_off    = 28'($urandom);
      reg_tgt    = {$urandom, $urandom};
      link_dest  = 6'($urandom);
      irq_vec    = {$urandom, $urandom};
      misp_tgt   = {$urandom, $urandom};
      eret_pc    = {$urandom, $urandom};
      step();
    end

    // R1 reset mid-run
    quiet(); rst = 1; @(posedge clk); #1;
    check64("R1", "reset pc again", pc, RST_PC);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule